// File: doc/BRIEF.md
# End-of-Write Status Read Path

This block sits on the read side of a byte-wide parallel memory port. When no internal write cycle is running, it passes the array's read data to the output bus. While the write engine reports busy, it replaces the array data with a status word. The host can then find the end of the write in two ways. It can watch the top bit, which reads as the inverse of the last written byte's top bit. Or it can watch bit 6, which changes value on every completed read.

The read strobes are active-low chip select, output enable and write enable. They are sampled on the block clock. The end of a read is the clock on which a read that was active is no longer active. Raising chip select, output enable or both ends a read, and any of these advances the toggling bit.

The toggle register reloads to a parameter value whenever a new write cycle starts. A rejected protected write raises busy in the same way as a real write, so no special case is needed here. The output bus is combinational from the strobes, busy, the last written byte and the toggle register. The enable for the tri-state drivers is also combinational.

Top module: `eow_status_rd`

## Requirements
- R1: `rd_oe` is 1 exactly when `cs_n` is 0, `oe_n` is 0 and `we_n` is 1, in the same cycle; otherwise it is 0.
- R2: While `busy` is 0, `rd_data` equals `arr_data`.
- R3: While `busy` is 1, bit 7 of `rd_data` is the inverse of bit 7 of `last_wr`.
- R4: While `busy` is 1, bit 6 of `rd_data` shows the toggle register. The register inverts once on each clock that ends a read and holds its value on every other clock.
- R5: A read ends on the clock after it was sampled active, when `cs_n` or `oe_n` (or both) is sampled high. Either strobe alone advances the toggle.
- R6: The toggle register takes the value `TOG_INIT` (default 0) during reset and on the first clock at which `busy` is sampled 1 after being 0. The first poll of a new write therefore shows bit 6 equal to `TOG_INIT`.
- R7: While `busy` is 1, bits 5..0 of `rd_data` equal bits 5..0 of `last_wr`, and they follow changes to `last_wr`.
- R8: When `busy` changes, `rd_data` switches between status and array data in the same cycle, including in the middle of an active read. Bit 6 no longer changes once `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| busy | input | 1 | Internal write cycle in progress |
| last_wr | input | DATA_W | Last byte latched by the write path |
| arr_data | input | DATA_W | Array read data |
| rd_data | output | DATA_W | Read bus value |
| rd_oe | output | 1 | Drive enable for the tri-state pads |

## Verification
The reads use four strobe patterns: a read ended by output enable, one ended by chip select, one ended by both, and no read at all. Comparing these shows whether each kind of end advances the toggle and whether idle clocks leave it alone. Write enable held low during an otherwise valid read separates the enable decode from the data path. The last written byte changes in the middle of a write, with both values of its top bit, which exposes a status word built from stale or wrongly inverted data. The bench starts a new write after an earlier write left the toggle at 1, applies a reset while busy, and clears busy during an active read. These cases show the reload value and that the switch between status and array data takes effect in the same cycle.

// File: rtl/eow_status_pkg.sv
package eow_status_pkg;

  typedef enum logic [1:0] {
    ROLE_COPY = 2'd0,
    ROLE_POLL = 2'd1,
    ROLE_TOG  = 2'd2
  } bit_role_e;

  // Role of one output bit while a write cycle is busy.
  function automatic bit_role_e bit_role(input int idx, input int poll_pos, input int tog_pos);
    if (idx == poll_pos)     return ROLE_POLL;
    else if (idx == tog_pos) return ROLE_TOG;
    else                     return ROLE_COPY;
  endfunction

  // Value of one status bit given its role.
  function automatic logic status_bit(input bit_role_e role, input logic wr_bit, input logic tog);
    case (role)
      ROLE_POLL: return ~wr_bit;
      ROLE_TOG:  return tog;
      default:   return wr_bit;
    endcase
  endfunction

endpackage

// File: rtl/eow_strobe.sv
module eow_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic oe_n,
  input  logic we_n,
  output logic rd_now,
  output logic read_end
);
  logic rd_q;

  assign rd_now = ~cs_n & ~oe_n & we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_now;
  end

  assign read_end = rd_q & ~rd_now;
endmodule

// File: rtl/eow_toggle.sv
module eow_toggle #(
  parameter logic TOG_INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic read_end,
  output logic wr_start,
  output logic tog_q
);
  logic busy_q;
  logic flip;

  assign wr_start = busy & ~busy_q;
  assign flip     = busy & read_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tog_q  <= TOG_INIT;
    end else begin
      busy_q <= busy;
      if (wr_start)  tog_q <= TOG_INIT;
      else if (flip) tog_q <= ~tog_q;
    end
  end
endmodule

// File: rtl/eow_outmux.sv
module eow_outmux
  import eow_status_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int POLL_POS = 7,
  parameter int TOG_POS  = 6
) (
  input  logic              busy,
  input  logic              tog_q,
  input  logic [DATA_W-1:0] last_wr,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] stat_word;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam bit_role_e ROLE = bit_role(i, POLL_POS, TOG_POS);
    assign stat_word[i] = status_bit(ROLE, last_wr[i], tog_q);
  end

  assign rd_data = busy ? stat_word : arr_data;
endmodule

// File: rtl/eow_status_rd.sv
module eow_status_rd #(
  parameter int   DATA_W   = 8,
  parameter int   POLL_POS = 7,
  parameter int   TOG_POS  = 6,
  parameter logic TOG_INIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              busy,
  input  logic [DATA_W-1:0] last_wr,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe
);
  // Named internal events, brought out for the checker.
  logic rd_now;
  logic read_end;
  logic wr_start;
  logic tog_q;

  eow_strobe strobe_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .rd_now   (rd_now),
    .read_end (read_end)
  );

  eow_toggle #(.TOG_INIT(TOG_INIT)) toggle_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .read_end (read_end),
    .wr_start (wr_start),
    .tog_q    (tog_q)
  );

  eow_outmux #(.DATA_W(DATA_W), .POLL_POS(POLL_POS), .TOG_POS(TOG_POS)) mux_i (
    .busy     (busy),
    .tog_q    (tog_q),
    .last_wr  (last_wr),
    .arr_data (arr_data),
    .rd_data  (rd_data)
  );

  assign rd_oe = rd_now;
endmodule

// File: rtl/eow_status_rd_chk.sv
module eow_status_rd_chk #(
  parameter int   DATA_W   = 8,
  parameter int   POLL_POS = 7,
  parameter int   TOG_POS  = 6,
  parameter logic TOG_INIT = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              busy,
  input logic [DATA_W-1:0] last_wr,
  input logic [DATA_W-1:0] arr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_oe,
  input logic              read_end,
  input logic              wr_start,
  input logic              tog_q
);
  localparam logic [DATA_W-1:0] COPY_MASK =
    ~((DATA_W'(1) << POLL_POS) | (DATA_W'(1) << TOG_POS));

  AST_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || oe_n || !we_n) |-> !rd_oe);                                  // R1
  AST_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !oe_n && we_n) |-> rd_oe);                                  // R1
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_data == arr_data));                                     // R2
  AST_POLL_INV: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_data[POLL_POS] != last_wr[POLL_POS]));                  // R3
  AST_TOG_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_data[TOG_POS] == tog_q));                                // R4
  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && read_end && !wr_start) |=> (tog_q != $past(tog_q)));         // R4
  AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(busy && read_end) && !wr_start) |=> $stable(tog_q));               // R4
  AST_TOG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> (tog_q == TOG_INIT));                                    // R6
  AST_COPY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (((rd_data ^ last_wr) & COPY_MASK) == '0));                  // R7
endmodule

bind eow_status_rd eow_status_rd_chk #(
  .DATA_W(DATA_W), .POLL_POS(POLL_POS), .TOG_POS(TOG_POS), .TOG_INIT(TOG_INIT)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .oe_n     (oe_n),
  .we_n     (we_n),
  .busy     (busy),
  .last_wr  (last_wr),
  .arr_data (arr_data),
  .rd_data  (rd_data),
  .rd_oe    (rd_oe),
  .read_end (read_end),
  .wr_start (wr_start),
  .tog_q    (tog_q)
);

// File: tb/eow_status_rd_tb_top.sv
module eow_status_rd_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0;
  logic [7:0] last_wr = 8'h00, arr_data = 8'h00;
  logic [7:0] rd_data;
  logic       rd_oe;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  eow_status_rd dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .busy(busy), .last_wr(last_wr), .arr_data(arr_data),
    .rd_data(rd_data), .rd_oe(rd_oe)
  );

  // Entry: {cs_n, oe_n, we_n, busy, last_wr, arr_data, exp_oe, exp_data}
  localparam int NV = 15;
  localparam logic [28:0] VEC [NV] = '{
    {4'b1110, 8'h00, 8'h3C, 1'b0, 8'h3C},  // idle, no read
    {4'b0010, 8'h00, 8'h5A, 1'b1, 8'h5A},  // idle read
    {4'b0000, 8'h00, 8'hA5, 1'b0, 8'hA5},  // write enable low blocks drive
    {4'b1111, 8'h96, 8'h11, 1'b0, 8'h16},  // write starts, toggle 0
    {4'b0011, 8'h96, 8'h11, 1'b1, 8'h16},  // poll read
    {4'b0111, 8'h96, 8'h11, 1'b0, 8'h56},  // ended by oe: toggle 1
    {4'b0011, 8'h96, 8'h11, 1'b1, 8'h56},
    {4'b1011, 8'h96, 8'h11, 1'b0, 8'h16},  // ended by cs: toggle 0
    {4'b0011, 8'h3F, 8'h11, 1'b1, 8'hBF},  // new last byte, top bit 0
    {4'b1111, 8'h3F, 8'h11, 1'b0, 8'hFF},  // ended by both: toggle 1
    {4'b1110, 8'h3F, 8'hC3, 1'b0, 8'hC3},  // write done
    {4'b0010, 8'h3F, 8'hC3, 1'b1, 8'hC3},
    {4'b1110, 8'h3F, 8'h0F, 1'b0, 8'h0F},  // idle read end
    {4'b1111, 8'h80, 8'h0F, 1'b0, 8'h00},  // new write reloads toggle 0
    {4'b0011, 8'h80, 8'h0F, 1'b1, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic c, input logic o, input logic w, input logic b);
    cs_n = c; oe_n = o; we_n = w; busy = b;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset", {7'd0, rd_oe}, 8'h00);
    chk("R2 reset", rd_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      apply(v[28], v[27], v[26], v[25]);
      last_wr  = v[24:17];
      arr_data = v[16:9];
      @(negedge clk);
      chk("R1 vector", {7'd0, rd_oe}, {7'd0, v[8]});
      if (v[25]) chk("R3/R4/R5/R6/R7 vector", rd_data, v[7:0]);
      else       chk("R2/R8 vector", rd_data, v[7:0]);
    end
    // Continue the write: end the read by oe, toggle goes to 1.
    apply(1'b0, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    chk("R4 flip", rd_data, 8'h40);
    // Idle clocks with no read leave the toggle unchanged.
    repeat (3) @(negedge clk);
    chk("R4 hold", rd_data, 8'h40);
    // Busy drops during an active read: array data at once.
    apply(1'b0, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    chk("R4 poll", rd_data, 8'h40);
    busy = 1'b0; arr_data = 8'h77;
    #0.5;
    chk("R8 busy drop", rd_data, 8'h77);
    @(negedge clk);
    // Read ends while idle, then the same clocks again: output stays array.
    apply(1'b1, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    chk("R8 no toggle idle", rd_data, 8'h77);
    // Busy rises during an active read: status at once, toggle reloaded.
    apply(1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    busy = 1'b1; last_wr = 8'h01;
    #0.5;
    chk("R8 busy rise", rd_data[7], 1'b1);
    @(negedge clk);
    chk("R6 reload mid read", rd_data, 8'h81);
    apply(1'b1, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    chk("R5 cs end", rd_data, 8'hC1);
    // Reset while busy with toggle at 1: comes back at the initial value.
    rst_n = 1'b0;
    @(negedge clk);
    chk("R6 reset", rd_data, 8'h81);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 after reset", rd_data, 8'h81);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule